// File: doc/BRIEF.md
# I2C Byte Master with Sub-Address Sequencing

This block is a byte-level I2C bus master controlled through eight byte-wide registers. Software sets the target address, the transaction shape and the bus rate. It then steps the transfer one byte at a time: it starts the addressing phase, and afterwards it supplies or fetches each data byte and finally requests a stop. Three interrupt flags mark the points where software must act: addressing finished, data byte finished, and stop finished.

The addressing phase takes one of three shapes, chosen by a field in the mode register:
- **Plain:** start, then the address byte.
- **Sub-address:** start, the address byte, then an 8-bit sub-address byte, and the data phase follows in the same transaction.
- **Combined:** start, the address byte with the direction bit forced to write, the sub-address byte, a repeated start, and then the address byte again as written.

The hardware chains all of these bytes by itself and raises a single flag when the chain is done. SCL and SDA are driven open-drain: an output high pulls the line low. A channel number from the mode register is presented on a separate output so that a bus multiplexer can be selected.

Top module: `i2c_submaster`

Register offsets: 0 mode, 1 control, 2 status, 3 interrupt status, 4 interrupt enable, 5 address, 6 sub-address, 7 data.

## Requirements
- R1: Writing control bit 0 emits a start, then the address register byte (bit 0 = 1 read, 0 write), then a ninth clock for the acknowledge. In plain mode (mode bits [3:2] = 0) the interrupt-status bit 0 (ADDR) then sets, and status bit 0 reads 1 when the slave pulled SDA low on that ninth clock and 0 otherwise.
- R2: With mode bits [3:2] = 1, an acknowledged address byte is followed by the sub-address register byte with no further start. ADDR sets after the sub-address byte.
- R3: With mode bits [3:2] = 2, the first address byte is sent with bit 0 cleared. The sub-address byte follows, then a repeated start, then the address register byte unchanged, and then ADDR sets.
- R4: In the write direction, writing the data register after ADDR sends that byte. Interrupt-status bit 1 (DATA) then sets, and status bit 0 reports its acknowledge.
- R5: In the read direction, a control write with bit 3 set receives one byte, which then reads back from the data register, and DATA sets. If bit 1 of that same write is 1, the master pulls SDA low on the ninth clock; if it is 0, the master leaves SDA released on the ninth clock.
- R6: Control bit 2 produces a stop: SDA rises while SCL is high. Interrupt-status bit 2 (STOP) then sets, status bit 1 (busy) reads 0 and both lines are released.
- R7: Mode bits [1:0] = 0, 1, 2 give a quarter-bit time of DIV_Q, 2·DIV_Q and 4·DIV_Q clocks, so each SCL high pulse lasts twice that.
- R8: Mode bits [7:4] appear on the channel-select output.
- R9: Writing 1 to an interrupt-status bit clears it; writing 0 leaves it set.
- R10: irq is high exactly when some interrupt-status bit is set and its bit in the enable register is 1. With the enable register at 0, irq stays low.
- R11: When hardware sets a flag in the same cycle that software clears it, the flag ends set.
- R12: During address and data bits, SDA does not change while SCL is released.
- R13: After reset every register reads 0, both lines are released and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for read and write |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for regAddr |
| irq | output | 1 | Interrupt request |
| chanSel | output | CHAN_W | Bus channel number |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| sdaIn | input | 1 | Sensed SDA level |

## Verification
Two things can land in the same clock edge: a hardware flag being set when a byte completes, and a software write-one-to-clear of the interrupt-status register. The bench provokes this by issuing a clear of every flag on every cycle while a data byte is in flight, and it stops the clears only when irq is seen high. If the clear had won, irq would never rise. The bench judges the outcome by irq rising and by the DATA bit still reading 1 once the writes stop.

// File: rtl/i2csm_pkg.sv
package i2csm_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE} engOp_e;

  // Strobes from the sequencer to the bit engine.
  typedef struct packed {
    logic       go;
    engOp_e     op;
    logic [8:0] txWord;   // eight data bits then the ninth (acknowledge) slot
  } engCmd_t;

  typedef enum logic [1:0] {SHAPE_PLAIN = 2'd0, SHAPE_SUB = 2'd1, SHAPE_COMB = 2'd2} shape_e;

  localparam logic [2:0] RA_MODE = 3'd0;
  localparam logic [2:0] RA_CTRL = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_ISR  = 3'd3;
  localparam logic [2:0] RA_IER  = 3'd4;
  localparam logic [2:0] RA_ADDR = 3'd5;
  localparam logic [2:0] RA_SUB  = 3'd6;
  localparam logic [2:0] RA_DATA = 3'd7;
endpackage

// File: rtl/i2csm_phy.sv
module i2csm_phy
  import i2csm_pkg::*;
#(
  parameter int DIV_Q = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  engCmd_t    cmd,
  input  logic [1:0] rateSel,
  input  logic       sdaIn,
  output logic       busy,
  output logic       done,
  output logic [8:0] rxWord,
  output logic       sclOe,
  output logic       sdaOe
);
  localparam int CNT_W = $clog2(DIV_Q * 4) + 1;

  logic             busyQ, doneQ, holdScl, holdSda, lowScl, lowSda;
  engOp_e           opQ;
  logic [1:0]       phase, shamt, sdaSync;
  logic [3:0]       bitIdx;
  logic [8:0]       txSh, rxSh;
  logic [CNT_W-1:0] divCnt, qLimit;

  assign shamt  = (rateSel == 2'd0) ? 2'd0 : (rateSel == 2'd1) ? 2'd1 : 2'd2;
  assign qLimit = (CNT_W'(DIV_Q) << shamt) - CNT_W'(1);

  // Line levels per symbol phase; 1 means pull low.
  always_comb begin
    lowScl = 1'b0;
    lowSda = 1'b0;
    case (opQ)
      OP_START: case (phase)
        2'd0: lowScl = 1'b1;
        2'd1: ;
        2'd2: lowSda = 1'b1;
        default: begin lowScl = 1'b1; lowSda = 1'b1; end
      endcase
      OP_STOP: case (phase)
        2'd0: begin lowScl = 1'b1; lowSda = 1'b1; end
        2'd1: lowSda = 1'b1;
        default: ;
      endcase
      default: begin
        lowSda = !txSh[8];
        lowScl = (phase == 2'd0) || (phase == 2'd3);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0; doneQ <= 1'b0; opQ <= OP_START; phase <= 2'd0;
      bitIdx <= 4'd0; txSh <= '0; rxSh <= '0; divCnt <= '0;
      sdaSync <= 2'b11; holdScl <= 1'b0; holdSda <= 1'b0;
    end else begin
      doneQ   <= 1'b0;
      sdaSync <= {sdaSync[0], sdaIn};
      if (busyQ) begin
        holdScl <= lowScl;
        holdSda <= lowSda;
      end
      if (!busyQ && cmd.go) begin
        busyQ <= 1'b1; opQ <= cmd.op; txSh <= cmd.txWord;
        phase <= 2'd0; bitIdx <= 4'd0; divCnt <= '0;
      end else if (busyQ) begin
        if (divCnt == qLimit) begin
          divCnt <= '0;
          if (phase == 2'd2 && opQ == OP_BYTE) rxSh <= {rxSh[7:0], sdaSync[1]};
          if (phase == 2'd3) begin
            if (opQ == OP_BYTE && bitIdx != 4'd8) begin
              bitIdx <= bitIdx + 4'd1;
              txSh   <= {txSh[7:0], 1'b1};
              phase  <= 2'd0;
            end else begin
              busyQ <= 1'b0;
              doneQ <= 1'b1;
            end
          end else begin
            phase <= phase + 2'd1;
          end
        end else begin
          divCnt <= divCnt + CNT_W'(1);
        end
      end
    end
  end

  assign busy   = busyQ;
  assign done   = doneQ;
  assign rxWord = rxSh;
  assign sclOe  = busyQ ? lowScl : holdScl;
  assign sdaOe  = busyQ ? lowSda : holdSda;

  // R12: data bits settle only while SCL is held low
  a_r12_sda_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && opQ == OP_BYTE && !sclOe) |=> (sclOe || $stable(sdaOe)));

  // R1: every symbol spans several clocks, so completion is a single pulse
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
endmodule

// File: rtl/i2csm_seq.sv
module i2csm_seq
  import i2csm_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irq,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic [8:0]        engRx,
  output engCmd_t           cmd,
  output logic [1:0]        rateSel,
  output logic [CHAN_W-1:0] chanSel
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR1, S_SUB, S_RSTART, S_ADDR2, S_HOLD, S_XFER, S_STOP
  } seqSt_e;

  seqSt_e     st, stNext;
  logic [7:0] modeReg, addrReg, subReg, dataRx;
  logic [2:0] isr, ier, isrClr, setVec;
  logic       ackEn, stopPend, lastAck;
  logic       wrCtrl, startReq, fetchReq, dataWr, isRead, nack;
  shape_e     shape;

  assign wrCtrl   = wrEn && regAddr == RA_CTRL;
  assign startReq = wrCtrl && wrData[0];
  assign fetchReq = wrCtrl && wrData[3];
  assign dataWr   = wrEn && regAddr == RA_DATA;
  assign isrClr   = (wrEn && regAddr == RA_ISR) ? wrData[2:0] : 3'b000;
  assign shape    = shape_e'(modeReg[3:2]);
  assign isRead   = addrReg[0];
  assign nack     = engRx[0];

  always_comb begin
    stNext = st;
    cmd    = '0;
    setVec = 3'b000;
    case (st)
      S_IDLE: if (startReq) begin
        cmd.go = 1'b1; cmd.op = OP_START; stNext = S_START;
      end
      S_START: if (engDone) begin
        cmd.go = 1'b1; cmd.op = OP_BYTE;
        cmd.txWord = {addrReg[7:1], (shape == SHAPE_COMB) ? 1'b0 : addrReg[0], 1'b1};
        stNext = S_ADDR1;
      end
      S_ADDR1: if (engDone) begin
        if (nack || shape == SHAPE_PLAIN) begin
          setVec[0] = 1'b1; stNext = S_HOLD;
        end else begin
          cmd.go = 1'b1; cmd.op = OP_BYTE; cmd.txWord = {subReg, 1'b1}; stNext = S_SUB;
        end
      end
      S_SUB: if (engDone) begin
        if (nack || shape == SHAPE_SUB) begin
          setVec[0] = 1'b1; stNext = S_HOLD;
        end else begin
          cmd.go = 1'b1; cmd.op = OP_START; stNext = S_RSTART;
        end
      end
      S_RSTART: if (engDone) begin
        cmd.go = 1'b1; cmd.op = OP_BYTE; cmd.txWord = {addrReg, 1'b1}; stNext = S_ADDR2;
      end
      S_ADDR2: if (engDone) begin
        setVec[0] = 1'b1; stNext = S_HOLD;
      end
      S_HOLD: begin
        if (stopPend) begin
          cmd.go = 1'b1; cmd.op = OP_STOP; stNext = S_STOP;
        end else if (dataWr && !isRead) begin
          cmd.go = 1'b1; cmd.op = OP_BYTE; cmd.txWord = {wrData, 1'b1}; stNext = S_XFER;
        end else if (fetchReq && isRead) begin
          cmd.go = 1'b1; cmd.op = OP_BYTE; cmd.txWord = {8'hFF, !wrData[1]}; stNext = S_XFER;
        end
      end
      S_XFER: if (engDone) begin
        setVec[1] = 1'b1; stNext = S_HOLD;
      end
      S_STOP: if (engDone) begin
        setVec[2] = 1'b1; stNext = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; modeReg <= '0; addrReg <= '0; subReg <= '0; dataRx <= '0;
      isr <= '0; ier <= '0; ackEn <= 1'b0; stopPend <= 1'b0; lastAck <= 1'b0;
    end else begin
      st  <= stNext;
      isr <= (isr & ~isrClr) | setVec;
      if (wrEn && regAddr == RA_MODE) modeReg <= wrData;
      if (wrEn && regAddr == RA_IER)  ier     <= wrData[2:0];
      if (wrEn && regAddr == RA_ADDR) addrReg <= wrData;
      if (wrEn && regAddr == RA_SUB)  subReg  <= wrData;
      if (wrCtrl) ackEn <= wrData[1];
      if (wrCtrl && wrData[2])                 stopPend <= 1'b1;
      else if (st == S_IDLE || st == S_HOLD)   stopPend <= 1'b0;
      if (engDone && (st inside {S_ADDR1, S_SUB, S_ADDR2} || (st == S_XFER && !isRead)))
        lastAck <= !engRx[0];
      if (engDone && st == S_XFER && isRead) dataRx <= engRx[8:1];
    end
  end

  always_comb begin
    case (regAddr)
      RA_MODE: rdData = modeReg;
      RA_CTRL: rdData = {6'd0, ackEn, 1'b0};
      RA_STAT: rdData = {6'd0, st != S_IDLE, lastAck};
      RA_ISR:  rdData = {5'd0, isr};
      RA_IER:  rdData = {5'd0, ier};
      RA_ADDR: rdData = addrReg;
      RA_SUB:  rdData = subReg;
      default: rdData = dataRx;
    endcase
  end

  assign irq     = |(isr & ier);
  assign rateSel = modeReg[1:0];
  assign chanSel = modeReg[4 +: CHAN_W];

  // R1: a new symbol is only requested of an idle engine
  a_r1_go_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> !engBusy);

  // R9: a flag not cleared by software survives to the next cycle
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((isr & $past(isr & ~isrClr)) == $past(isr & ~isrClr)));

  // R11: a hardware set is visible next cycle even with a clear in flight
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((isr & $past(setVec)) == $past(setVec)));
endmodule

// File: rtl/i2c_submaster.sv
module i2c_submaster
  import i2csm_pkg::*;
#(
  parameter int DIV_Q  = 4,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irq,
  output logic [CHAN_W-1:0] chanSel,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              sdaIn
);
  engCmd_t    cmd;
  logic       engBusy, engDone;
  logic [8:0] engRx;
  logic [1:0] rateSel;

  i2csm_seq #(.CHAN_W(CHAN_W)) seq_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .engBusy(engBusy), .engDone(engDone),
    .engRx(engRx), .cmd(cmd), .rateSel(rateSel), .chanSel(chanSel)
  );

  i2csm_phy #(.DIV_Q(DIV_Q)) phy_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rateSel(rateSel), .sdaIn(sdaIn),
    .busy(engBusy), .done(engDone), .rxWord(engRx), .sclOe(sclOe), .sdaOe(sdaOe)
  );
endmodule

// File: tb/i2c_submaster_tb_top.sv
module i2c_submaster_tb_top;
  localparam int DIV_Q = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq, sclOe, sdaOe;
  logic [3:0] chanSel;

  logic slvDrive = 1'b0, slvAck = 1'b1, slvSending = 1'b0, mAck = 1'b0;
  logic [7:0] slvTx = 8'd0, rxSh = 8'd0;
  logic [7:0] logB [0:15];
  int bitCnt = 0, logN = 0, startCnt = 0, stopCnt = 0;
  int nChecks = 0, nFail = 0;

  wire sclBus = !sclOe;
  wire sdaBus = !(sdaOe || slvDrive);

  always #4 clk = ~clk;

  i2c_submaster #(.DIV_Q(DIV_Q), .CHAN_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .chanSel(chanSel), .sclOe(sclOe), .sdaOe(sdaOe),
    .sdaIn(sdaBus)
  );

  // Behavioural slave
  always @(posedge sclBus) begin
    if (bitCnt == 8) begin
      mAck = sdaBus;
      if (logN < 16) logB[logN] = rxSh;
      logN++;
      bitCnt = 0;
    end else begin
      rxSh = {rxSh[6:0], sdaBus};
      bitCnt++;
    end
  end
  always @(negedge sclBus) begin
    if (bitCnt == 8)     slvDrive = slvSending ? 1'b0 : slvAck;
    else if (slvSending) slvDrive = !slvTx[7 - bitCnt];
    else                 slvDrive = 1'b0;
  end
  always @(negedge sdaBus) if (sclBus) begin startCnt++; bitCnt = 0; end
  always @(posedge sdaBus) if (sclBus) stopCnt++;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = rdData;
  endtask

  task automatic waitFlag(int b);
    logic [7:0] v;
    for (int i = 0; i < 6000; i++) begin
      regRead(3'd3, v);
      if (v[b]) break;
    end
  endtask

  task automatic clrBus();
    logN = 0; startCnt = 0; stopCnt = 0; bitCnt = 0;
  endtask

  task automatic doStop();
    regWrite(3'd1, 8'h04); waitFlag(2); regWrite(3'd3, 8'h07);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int r = 0; r < 8; r++) begin
      regRead(3'(r), v);
      chk($sformatf("R13 reg%0d", r), v, 0);
    end
    chk("R13 lines", {sclOe, sdaOe}, 0);
    chk("R13 irq", irq, 0);
  endtask

  task automatic t_plain_write();
    logic [7:0] v;
    clrBus(); slvAck = 1'b1;
    regWrite(3'd4, 8'h07); regWrite(3'd0, 8'h30); regWrite(3'd5, 8'hA0);
    regWrite(3'd1, 8'h01); waitFlag(0);
    chk("R1 addr byte", logB[0], 8'hA0);
    chk("R1 one start", startCnt, 1);
    regRead(3'd2, v); chk("R1 ack status", v[0], 1);
    chk("R8 channel", chanSel, 3);
    chk("R10 irq on", irq, 1);
    regWrite(3'd3, 8'h00); regRead(3'd3, v); chk("R9 zero write keeps", v[0], 1);
    regWrite(3'd3, 8'h01); regRead(3'd3, v); chk("R9 one write clears", v[0], 0);
    regWrite(3'd7, 8'h3C); waitFlag(1);
    chk("R4 data byte", logB[1], 8'h3C);
    regRead(3'd2, v); chk("R4 ack status", v[0], 1);
    regWrite(3'd4, 8'h00); #1 chk("R10 masked", irq, 0);
    regWrite(3'd4, 8'h07); regWrite(3'd3, 8'h07);
    regWrite(3'd1, 8'h04); waitFlag(2);
    chk("R6 stop seen", stopCnt, 1);
    regRead(3'd2, v); chk("R6 not busy", v[1], 0);
    chk("R6 lines released", {sclOe, sdaOe}, 0);
    regWrite(3'd3, 8'h07);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    clrBus(); slvAck = 1'b0;
    regWrite(3'd0, 8'h00); regWrite(3'd5, 8'hA0); regWrite(3'd1, 8'h01); waitFlag(0);
    regRead(3'd2, v); chk("R1 nack status", v[0], 0);
    slvAck = 1'b1; regWrite(3'd3, 8'h07); doStop();
  endtask

  task automatic t_sub_read();
    logic [7:0] v;
    clrBus();
    regWrite(3'd0, 8'h04); regWrite(3'd5, 8'hA1); regWrite(3'd6, 8'h12);
    regWrite(3'd1, 8'h01); waitFlag(0);
    chk("R2 addr", logB[0], 8'hA1);
    chk("R2 sub", logB[1], 8'h12);
    chk("R2 bytes", logN, 2);
    chk("R2 single start", startCnt, 1);
    regWrite(3'd3, 8'h07);
    slvTx = 8'h5A; slvSending = 1'b1; slvDrive = !slvTx[7];
    regWrite(3'd1, 8'h0A); waitFlag(1);
    regRead(3'd7, v); chk("R5 read byte", v, 8'h5A);
    chk("R5 master ack low", mAck, 0);
    regWrite(3'd3, 8'h07);
    slvTx = 8'hC3; slvDrive = !slvTx[7];
    regWrite(3'd1, 8'h08); waitFlag(1);
    slvSending = 1'b0; slvDrive = 1'b0;
    regRead(3'd7, v); chk("R5 read byte two", v, 8'hC3);
    chk("R5 master no ack", mAck, 1);
    regWrite(3'd3, 8'h07); doStop();
  endtask

  task automatic t_combined();
    clrBus();
    regWrite(3'd0, 8'h08); regWrite(3'd5, 8'hA1); regWrite(3'd6, 8'h34);
    regWrite(3'd1, 8'h01); waitFlag(0);
    chk("R3 first addr write", logB[0], 8'hA0);
    chk("R3 sub", logB[1], 8'h34);
    chk("R3 readdr", logB[2], 8'hA1);
    chk("R3 two starts", startCnt, 2);
    regWrite(3'd3, 8'h07); doStop();
  endtask

  task automatic t_rate();
    for (int r = 1; r <= 2; r++) begin
      int cnt = 0;
      clrBus();
      regWrite(3'd0, 8'(r)); regWrite(3'd5, 8'hA0); regWrite(3'd1, 8'h01);
      @(posedge sclBus);
      forever begin
        @(negedge clk);
        if (sclBus) cnt++; else break;
      end
      chk($sformatf("R7 high time rate%0d", r), cnt, 2 * (DIV_Q << r));
      waitFlag(0); regWrite(3'd3, 8'h07); doStop();
    end
  endtask

  task automatic t_collide();
    logic [7:0] v;
    logic seen = 1'b0;
    clrBus();
    regWrite(3'd0, 8'h00); regWrite(3'd4, 8'h07); regWrite(3'd5, 8'hA0);
    regWrite(3'd1, 8'h01); waitFlag(0); regWrite(3'd3, 8'h07);
    regWrite(3'd7, 8'h81);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
      wrEn = 1'b1; regAddr = 3'd3; wrData = 8'h07;
    end
    wrEn = 1'b0;
    chk("R11 irq despite clear", seen, 1);
    regRead(3'd3, v); chk("R11 data flag kept", v[1], 1);
    regWrite(3'd3, 8'h07); doStop();
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    clrBus();
    t_reset();
    t_plain_write();
    t_nack();
    t_sub_read();
    t_combined();
    t_rate();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule